// File: doc/BRIEF.md
# Serial Configuration Register Target

This block is a two-wire serial bus target that owns a bank of sixteen 8-bit configuration registers. It runs entirely in the system clock domain. The bus clock and data lines are first passed through synchronisers. Edge detection on the synchronised lines then finds START and STOP conditions and clock edges. The block drives the data line only through an open-drain pull-down enable. The whole register bank is presented as one flat parallel vector, so downstream logic can use every setting directly.

A bus controller addresses the target with a 7-bit address. Bit 2 of that address follows an external select pin, so two targets can share one bus. In a write, the first data byte after the address sets an internal register pointer. Each later byte is stored at the pointer, and the pointer then advances modulo sixteen. A read streams bytes out from the current pointer. A random read is done by setting the pointer in a write and then issuing a repeated START with the read address.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset every register reads zero on `regs_o` and `sda_oe_o` is low (line released).
- R2: A START (data falling while clock high) restarts address reception from any state, even mid-byte. A STOP (data rising while clock high) returns the block to idle. A partially received byte is discarded with no register write.
- R3: The target answers address bits A6..A0 = 1,0,1,1,S,0,0, where S is `addr_sel_i`. After its address byte it acknowledges by asserting `sda_oe_o` (line low) for the ninth clock; the eighth bit of the address byte is 0 for write and 1 for read.
- R4: Any other address, including the all-zero general-call address, is not acknowledged. The block then ignores the bus, keeps the line released and writes nothing until the next START.
- R5: In a write, the first byte after the address loads the register pointer from its low four bits and is acknowledged.
- R6: Every further write byte is stored in the register at the pointer and acknowledged, and the pointer then increments modulo 16, so byte seventeen overwrites register 0 again.
- R7: A read sends the register at the pointer MSB first and increments the pointer modulo 16 after each byte, wrapping from 15 to 0.
- R8: When the controller acknowledges a read byte, the next register follows. When it does not, the target releases the line and stays idle until a START.
- R9: `sda_oe_o` changes only while the bus clock is low.
- R10: Register k appears on `regs_o[8k+7:8k]` and changes only when a write byte completes.
- R11: The pointer persists between transfers, so a read with no pointer byte continues where the previous access left off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| addr_sel_i | input | 1 | Supplies address bit A2 |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| regs_o | output | 128 | All sixteen registers, register k at bits 8k+7..8k |

## Verification
The bench writes five bytes starting at pointer 14 and later eighteen bytes starting at 0. A design that failed to wrap the pointer would write past the bank or stall, and the continuously compared register image would diverge. Random, sequential and current-address reads check that the pointer carries across repeated STARTs and transfers. An off-by-one increment would return the neighbouring register. Wrong-select, general-call, and STARTs or STOPs mid-byte are exercised: a design that acknowledged them or committed a half byte would show a low acknowledge bit or a changed register. A master not-acknowledge is followed by a check that the line is released, which catches a target that keeps driving a data bit and blocks the STOP.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  // protocol engine state
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } bus_st_e;

  // meaning of the byte currently being received
  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } rx_phase_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic                   scl_q;
  logic                   sda_q;

  // idle bus is high, so everything resets high
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[SYNC_STAGES-1];
      sda_q    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
  parameter int AW = 4,
  parameter int DW = 8,
  localparam int NREG = 1 << AW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [DW-1:0]       rd_data,
  output logic [NREG*DW-1:0]  regs_flat
);

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*DW +: DW] = mem[g];
  end

endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
  import cfg_i2c_pkg::*;
#(
  parameter int           AW       = 4,
  parameter int           DW       = 8,
  parameter logic [6:0]   DEV_ADDR = 7'h58,
  parameter int           SEL_POS  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          addr_sel,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] ptr,
  output logic          sda_oe,
  output bus_st_e       st
);

  localparam int CW = $clog2(DW + 1);

  rx_phase_e     ph;
  logic [DW-1:0] rx_sh;
  logic [DW-1:0] tx_sh;
  logic [CW-1:0] bcnt;
  logic          rw;
  logic          mack;
  logic [6:0]    dev;

  always_comb begin
    dev          = DEV_ADDR;
    dev[SEL_POS] = addr_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      ph      <= PH_ADDR;
      rx_sh   <= '0;
      tx_sh   <= '0;
      bcnt    <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st     <= ST_RX;
        ph     <= PH_ADDR;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && bcnt != CW'(DW)) begin
              rx_sh <= {rx_sh[DW-2:0], sda_s};
              bcnt  <= bcnt + 1'b1;
            end else if (scl_fall && bcnt == CW'(DW)) begin
              bcnt <= '0;
              case (ph)
                PH_ADDR: begin
                  if (rx_sh[DW-1:1] == dev) begin
                    rw     <= rx_sh[0];
                    sda_oe <= 1'b1;
                    st     <= ST_RX_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                PH_PTR: begin
                  ptr    <= rx_sh[AW-1:0];
                  ph     <= PH_DATA;
                  sda_oe <= 1'b1;
                  st     <= ST_RX_ACK;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= rx_sh;
                  ptr     <= ptr + 1'b1;
                  sda_oe  <= 1'b1;
                  st      <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= ST_RX;
              if (ph == PH_ADDR) begin
                if (rw) begin
                  st     <= ST_TX;
                  tx_sh  <= rd_data;
                  sda_oe <= ~rd_data[DW-1];
                  bcnt   <= '0;
                end else begin
                  ph <= PH_PTR;
                end
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bcnt == CW'(DW - 1)) begin
                st     <= ST_TX_ACK;
                sda_oe <= 1'b0;
                ptr    <= ptr + 1'b1;
                bcnt   <= '0;
              end else begin
                bcnt   <= bcnt + 1'b1;
                tx_sh  <= {tx_sh[DW-2:0], 1'b0};
                sda_oe <= ~tx_sh[DW-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                st     <= ST_TX;
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[DW-1];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
  import cfg_i2c_pkg::*;
#(
  parameter int           ADDR_W      = 4,
  parameter int           DATA_W      = 8,
  parameter int           SYNC_STAGES = 2,
  parameter logic [6:0]   DEV_ADDR    = 7'h58,
  parameter int           SEL_POS     = 2,
  localparam int          NREG        = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic                   addr_sel_i,
  output logic                   sda_oe_o,
  output logic [NREG*DATA_W-1:0] regs_o
);

  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [ADDR_W-1:0] cur_ptr;
  logic [DATA_W-1:0] rd_data;
  bus_st_e           bus_st;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_proto_fsm #(
    .AW       (ADDR_W),
    .DW       (DATA_W),
    .DEV_ADDR (DEV_ADDR),
    .SEL_POS  (SEL_POS)
  ) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .addr_sel  (addr_sel_i),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ptr       (cur_ptr),
    .sda_oe    (sda_oe_o),
    .st        (bus_st)
  );

  cfg_regbank #(.AW(ADDR_W), .DW(DATA_W)) bank_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (cur_ptr),
    .rd_data   (rd_data),
    .regs_flat (regs_o)
  );

endmodule

// File: rtl/cfg_i2c_target_chk.sv
module cfg_i2c_target_chk
  import cfg_i2c_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int NREG  = 1 << ADDR_W
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   scl_s,
  input logic                   sda_oe_o,
  input logic [NREG*DATA_W-1:0] regs_o,
  input logic                   wr_en,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [ADDR_W-1:0]      cur_ptr,
  input bus_st_e                bus_st
);

  // R4 / R8: an idle engine never holds the line low
  p_idle_released_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_st == ST_IDLE) |-> !sda_oe_o);

  // R9: the pull-down only toggles while the synchronised clock is low
  p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> !scl_s);

  // R6: a write leaves the pointer one past the written register
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (cur_ptr == wr_addr + 1'b1));

  // R10: the register image moves only after a write strobe
  p_regs_on_write_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(regs_o) |-> $past(wr_en));

endmodule

bind cfg_i2c_target cfg_i2c_target_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .scl_s    (scl_s),
  .sda_oe_o (sda_oe_o),
  .regs_o   (regs_o),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .cur_ptr  (cur_ptr),
  .bus_st   (bus_st)
);

// File: tb/cfg_i2c_target_tb_top.sv
`timescale 1ns/1ps
module cfg_i2c_target_tb_top;

  localparam int Q = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         scl = 1'b1;
  logic         sda_m = 1'b1;
  logic         sel = 1'b1;
  logic         sda_oe;
  logic [127:0] regs;
  logic         sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  cfg_i2c_target dut_i (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .addr_sel_i (sel),
    .sda_oe_o   (sda_oe),
    .regs_o     (regs)
  );

  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;
  logic [7:0] mdl [16];
  int   mptr  = 0;
  int   mask  = 0;
  int   mism  = 0;
  int   r9_viol = 0;
  logic oe_prev = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_at(input int k);
    return regs[k*8 +: 8];
  endfunction

  // per-clock comparison of the register image against the bench model
  always @(negedge clk) begin
    if (!rst) begin
      if (mask > 0) mask--;
      else begin
        for (int k = 0; k < 16; k++)
          if (reg_at(k) !== mdl[k]) mism++;
      end
      if (sda_oe !== oe_prev && scl) r9_viol++;
    end
    oe_prev = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  // send a byte; if store is set the model records a register write
  task automatic wr_byte(input logic [7:0] d, input bit store, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) mask = 40;
      wbit(d[i]);
    end
    if (store) begin
      mdl[mptr] = d;
      mptr = (mptr + 1) % 16;
    end
    rbit(ack);
  endtask

  task automatic rd_byte(output logic [7:0] d, input bit give_ack);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      rbit(b);
      d[i] = b;
    end
    mptr = (mptr + 1) % 16;
    wbit(give_ack ? 1'b0 : 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    logic [7:0] exp_b;
    for (int k = 0; k < 16; k++) mdl[k] = 8'h00;
    tick(5);
    rst = 1'b0;
    tick(3);

    // R1: reset state
    chk("R1 regs after reset", regs[31:0] | regs[63:32] | regs[95:64] | regs[127:96], 32'h0);
    chk("R1 line released", {31'b0, sda_oe}, 32'h0);

    // R3/R5/R6: write 5 bytes from pointer 14, wrapping into 0..2
    sel = 1'b1;
    bus_start();
    wr_byte(8'hB8, 0, ack); chk("R3 address ack sel=1", {31'b0, ack}, 32'h0);
    wr_byte(8'h0E, 0, ack); chk("R5 pointer byte ack", {31'b0, ack}, 32'h0);
    mptr = 14;
    wr_byte(8'hA1, 1, ack); chk("R6 data ack", {31'b0, ack}, 32'h0);
    wr_byte(8'hB2, 1, ack);
    wr_byte(8'hC3, 1, ack); chk("R6 wrap write ack", {31'b0, ack}, 32'h0);
    wr_byte(8'hD4, 1, ack);
    wr_byte(8'hE5, 1, ack);
    bus_stop();
    chk("R10 reg15 field", {24'b0, regs[127:120]}, 32'hB2);
    chk("R6 wrapped to reg0", {24'b0, regs[7:0]}, 32'hC3);

    // R4: wrong select bit, then general call
    bus_start();
    wr_byte(8'hB0, 0, ack); chk("R4 mismatch nack", {31'b0, ack}, 32'h1);
    wr_byte(8'h03, 0, ack); chk("R4 ignored byte nack", {31'b0, ack}, 32'h1);
    wr_byte(8'hFF, 0, ack);
    bus_stop();
    chk("R4 reg3 untouched", {24'b0, reg_at(3)}, 32'h0);
    bus_start();
    wr_byte(8'h00, 0, ack); chk("R4 general call nack", {31'b0, ack}, 32'h1);
    wr_byte(8'h55, 0, ack); chk("R4 general call data nack", {31'b0, ack}, 32'h1);
    bus_stop();

    // R7/R8: random read from 15, wrapping to 0 and 1
    bus_start();
    wr_byte(8'hB8, 0, ack);
    wr_byte(8'h0F, 0, ack);
    mptr = 15;
    bus_start();
    wr_byte(8'hB9, 0, ack); chk("R3 read address ack", {31'b0, ack}, 32'h0);
    exp_b = mdl[mptr]; rd_byte(d, 1); chk("R7 read reg15", {24'b0, d}, {24'b0, exp_b});
    exp_b = mdl[mptr]; rd_byte(d, 1); chk("R7 read wraps to reg0", {24'b0, d}, {24'b0, exp_b});
    exp_b = mdl[mptr]; rd_byte(d, 0); chk("R7 read reg1", {24'b0, d}, {24'b0, exp_b});
    tick(2*Q);
    chk("R8 released after nack", {31'b0, sda_oe}, 32'h0);
    bus_stop();

    // R11: current-address read continues at pointer 2
    bus_start();
    wr_byte(8'hB9, 0, ack);
    exp_b = mdl[mptr]; rd_byte(d, 0); chk("R11 current address read", {24'b0, d}, {24'b0, exp_b});
    bus_stop();

    // R3: select low changes the answered address
    sel = 1'b0;
    bus_start();
    wr_byte(8'hB8, 0, ack); chk("R3 old address nack sel=0", {31'b0, ack}, 32'h1);
    bus_stop();
    bus_start();
    wr_byte(8'hB0, 0, ack); chk("R3 address ack sel=0", {31'b0, ack}, 32'h0);
    wr_byte(8'h05, 0, ack);
    mptr = 5;
    wr_byte(8'h3C, 1, ack);
    bus_stop();
    chk("R6 reg5 written", {24'b0, reg_at(5)}, 32'h3C);

    // R2: repeated START in the middle of a data byte
    bus_start();
    wr_byte(8'hB0, 0, ack);
    wr_byte(8'h07, 0, ack);
    mptr = 7;
    for (int i = 0; i < 4; i++) wbit(1'b1);
    bus_start();
    wr_byte(8'hB1, 0, ack); chk("R2 restart read ack", {31'b0, ack}, 32'h0);
    exp_b = mdl[mptr]; rd_byte(d, 0); chk("R2 aborted byte not stored", {24'b0, d}, {24'b0, exp_b});
    bus_stop();

    // R2: STOP in the middle of a data byte
    bus_start();
    wr_byte(8'hB0, 0, ack);
    wr_byte(8'h09, 0, ack);
    mptr = 9;
    for (int i = 0; i < 5; i++) wbit(1'b1);
    bus_stop();
    chk("R2 stop mid byte no write", {24'b0, reg_at(9)}, 32'h0);

    // R6/R7: eighteen bytes from 0, then read back all sixteen
    bus_start();
    wr_byte(8'hB0, 0, ack);
    wr_byte(8'h00, 0, ack);
    mptr = 0;
    for (int i = 0; i < 18; i++) wr_byte(8'(i*7 + 1), 1, ack);
    bus_stop();
    chk("R6 reg0 overwritten by byte 17", {24'b0, reg_at(0)}, 32'h71);
    bus_start();
    wr_byte(8'hB0, 0, ack);
    wr_byte(8'h00, 0, ack);
    mptr = 0;
    bus_start();
    wr_byte(8'hB1, 0, ack);
    for (int i = 0; i < 16; i++) begin
      exp_b = mdl[mptr];
      rd_byte(d, i != 15);
      chk("R7 sequential read", {24'b0, d}, {24'b0, exp_b});
    end
    bus_stop();
    tick(4*Q);

    chk("R10 per-clock register image", mism, 32'h0);
    chk("R9 line change while clock high", r9_viol, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule